// File: doc/BRIEF.md
# Ring Configuration Register Node

This block is one node on a daisy-chained 32-bit control ring. A single CPU master sends each transaction around the ring, and every node sees it in turn. The node holds the configuration registers of a memory controller and a read-only status word. Each transaction carries a valid flag, a write flag, an acknowledge flag, a 32-bit register address and 32 bits of data.

Each node compares the incoming address with its own four-register window. On a hit it writes the register or loads the register contents into the data field, then sets the acknowledge flag. On a miss, or when an earlier node has already acknowledged the transaction, it passes the transaction on unchanged. Every transaction leaves through a register, so each node adds exactly one cycle of latency. The acknowledge rides with the transaction back to the master.

The configuration fields drive the memory controller directly. The status word is sampled from a controller input at read time.

Top module: `cfgring_node`

## Requirements
- R1: While `rst_ni` is low and after its release with no traffic, `ring_vld_o` and `ring_ack_o` are 0, and `cfg_mode_o`, `cfg_refsel_o` and `cfg_ctrl_o` hold their reset parameters (defaults 12'h033, 2'd1, 8'h00).
- R2: A valid, unacknowledged transaction whose address misses the window leaves the node one clock later with `vld`, `wr`, `ack` (0), `addr` and `data` unchanged.
- R3: A cycle with `ring_vld_i` low produces `ring_vld_o` = 0 and `ring_ack_o` = 0 one clock later.
- R4: A hit write updates the addressed register at the clock edge that accepts it. The transaction leaves one clock later with `ack` = 1 and `wr`, `addr` and `data` unchanged.
- R5: A hit read leaves one clock later with `ack` = 1, `wr` = 0, `addr` unchanged, and `data` holding the addressed register zero-extended to 32 bits.
- R6: The status register returns `status_i` as sampled in the cycle the read arrives, zero-extended. A write to it is acknowledged but changes no register.
- R7: An address hits only when bits 31:4 equal those of `BASE` and bits 1:0 are 0. Bits 3:2 then select mode (0), refresh select (1), control (2) or status (3). Any other address misses.
- R8: A transaction that arrives with `ring_ack_i` = 1 is forwarded unchanged one clock later, even when its address hits, and no register changes.
- R9: A write stores only the low bits of the data that fit the field (mode 12, refresh select 2, control 8). A read returns 0 in all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ring_vld_i | input | 1 | Upstream transaction valid |
| ring_wr_i | input | 1 | Upstream write (1) / read (0) |
| ring_ack_i | input | 1 | Upstream already acknowledged |
| ring_addr_i | input | 32 | Upstream register address |
| ring_data_i | input | 32 | Upstream data |
| ring_vld_o | output | 1 | Downstream transaction valid |
| ring_wr_o | output | 1 | Downstream write flag |
| ring_ack_o | output | 1 | Downstream acknowledge |
| ring_addr_o | output | 32 | Downstream address |
| ring_data_o | output | 32 | Downstream data (read result on a hit read) |
| status_i | input | STAT_W | Live controller status |
| cfg_mode_o | output | MODE_W | Mode field |
| cfg_refsel_o | output | REFSEL_W | Refresh interval select |
| cfg_ctrl_o | output | CTRL_W | Control field |

## Verification
On every cycle, the assertions check the one-cycle forwarding relation between the upstream and downstream ports. This covers an idle slot, a miss, a hit, and a transaction that is already acknowledged. The assertions also check that neither a status write nor an acknowledged transaction moves any configuration output. The bench scenarios show the full decode of the window (the offset map, the misaligned miss and the miss one window above), the field masking, and that a read after a write returns the written value.

// File: rtl/cfgring_pkg.sv
package cfgring_pkg;
  localparam int RING_AW = 32;
  localparam int RING_DW = 32;

  typedef struct packed {
    logic               vld;
    logic               wr;
    logic               ack;
    logic [RING_AW-1:0] addr;
    logic [RING_DW-1:0] data;
  } ring_xfer_t;

  typedef enum logic [1:0] {
    REG_MODE   = 2'd0,
    REG_REFSEL = 2'd1,
    REG_CTRL   = 2'd2,
    REG_STATUS = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/cfgring_decode.sv
module cfgring_decode
  import cfgring_pkg::*;
#(
  parameter logic [RING_AW-1:0] BASE = 32'h0000_0400
) (
  input  ring_xfer_t xfer_i,
  output logic       hit_o,
  output reg_idx_e   idx_o
);
  localparam int WIN_LSB = 4;

  logic base_match, aligned;

  assign base_match = (xfer_i.addr[RING_AW-1:WIN_LSB] == BASE[RING_AW-1:WIN_LSB]);
  assign aligned    = (xfer_i.addr[1:0] == 2'b00);
  // already-acknowledged traffic is never claimed twice
  assign hit_o      = xfer_i.vld && !xfer_i.ack && base_match && aligned;
  assign idx_o      = reg_idx_e'(xfer_i.addr[3:2]);
endmodule

// File: rtl/cfgring_field.sv
module cfgring_field #(
  parameter int         W   = 8,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/cfgring_regfile.sv
module cfgring_regfile
  import cfgring_pkg::*;
#(
  parameter int MODE_W   = 12,
  parameter int REFSEL_W = 2,
  parameter int CTRL_W   = 8,
  parameter int STAT_W   = 8,
  parameter logic [MODE_W-1:0]   MODE_RST   = 12'h033,
  parameter logic [REFSEL_W-1:0] REFSEL_RST = 2'd1,
  parameter logic [CTRL_W-1:0]   CTRL_RST   = 8'h00
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  reg_idx_e            idx_i,
  input  logic [RING_DW-1:0]  wdata_i,
  input  logic [STAT_W-1:0]   status_i,
  output logic [RING_DW-1:0]  rdata_o,
  output logic [MODE_W-1:0]   mode_o,
  output logic [REFSEL_W-1:0] refsel_o,
  output logic [CTRL_W-1:0]   ctrl_o
);
  logic we_mode, we_refsel, we_ctrl;

  // status has no write strobe: writes are dropped here
  assign we_mode   = wr_en_i && (idx_i == REG_MODE);
  assign we_refsel = wr_en_i && (idx_i == REG_REFSEL);
  assign we_ctrl   = wr_en_i && (idx_i == REG_CTRL);

  cfgring_field #(.W(MODE_W), .RST(MODE_RST)) u_mode (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_mode),
    .d_i(wdata_i[MODE_W-1:0]), .q_o(mode_o));

  cfgring_field #(.W(REFSEL_W), .RST(REFSEL_RST)) u_refsel (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_refsel),
    .d_i(wdata_i[REFSEL_W-1:0]), .q_o(refsel_o));

  cfgring_field #(.W(CTRL_W), .RST(CTRL_RST)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_ctrl),
    .d_i(wdata_i[CTRL_W-1:0]), .q_o(ctrl_o));

  always_comb begin
    rdata_o = '0;
    unique case (idx_i)
      REG_MODE:   rdata_o[MODE_W-1:0]   = mode_o;
      REG_REFSEL: rdata_o[REFSEL_W-1:0] = refsel_o;
      REG_CTRL:   rdata_o[CTRL_W-1:0]   = ctrl_o;
      REG_STATUS: rdata_o[STAT_W-1:0]   = status_i;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cfgring_out_stage.sv
module cfgring_out_stage
  import cfgring_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  ring_xfer_t         xfer_i,
  input  logic               hit_i,
  input  logic [RING_DW-1:0] rdata_i,
  output ring_xfer_t         xfer_o
);
  ring_xfer_t nxt;

  always_comb begin
    nxt = xfer_i;
    if (!xfer_i.vld) begin
      nxt = '0;
    end else if (hit_i) begin
      nxt.ack = 1'b1;
      if (!xfer_i.wr) nxt.data = rdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) xfer_o <= '0;
    else         xfer_o <= nxt;
  end
endmodule

// File: rtl/cfgring_node.sv
module cfgring_node
  import cfgring_pkg::*;
#(
  parameter logic [31:0] BASE = 32'h0000_0400,
  parameter int MODE_W   = 12,
  parameter int REFSEL_W = 2,
  parameter int CTRL_W   = 8,
  parameter int STAT_W   = 8,
  parameter logic [MODE_W-1:0]   MODE_RST   = 12'h033,
  parameter logic [REFSEL_W-1:0] REFSEL_RST = 2'd1,
  parameter logic [CTRL_W-1:0]   CTRL_RST   = 8'h00
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ring_vld_i,
  input  logic                ring_wr_i,
  input  logic                ring_ack_i,
  input  logic [31:0]         ring_addr_i,
  input  logic [31:0]         ring_data_i,
  output logic                ring_vld_o,
  output logic                ring_wr_o,
  output logic                ring_ack_o,
  output logic [31:0]         ring_addr_o,
  output logic [31:0]         ring_data_o,
  input  logic [STAT_W-1:0]   status_i,
  output logic [MODE_W-1:0]   cfg_mode_o,
  output logic [REFSEL_W-1:0] cfg_refsel_o,
  output logic [CTRL_W-1:0]   cfg_ctrl_o
);
  ring_xfer_t         in_x, out_x;
  logic               hit;
  reg_idx_e           idx;
  logic [RING_DW-1:0] rdata;

  assign in_x = '{vld: ring_vld_i, wr: ring_wr_i, ack: ring_ack_i,
                  addr: ring_addr_i, data: ring_data_i};

  cfgring_decode #(.BASE(BASE)) u_dec (
    .xfer_i(in_x), .hit_o(hit), .idx_o(idx));

  cfgring_regfile #(
    .MODE_W(MODE_W), .REFSEL_W(REFSEL_W), .CTRL_W(CTRL_W), .STAT_W(STAT_W),
    .MODE_RST(MODE_RST), .REFSEL_RST(REFSEL_RST), .CTRL_RST(CTRL_RST)
  ) u_rf (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(hit && ring_wr_i), .idx_i(idx), .wdata_i(ring_data_i),
    .status_i(status_i), .rdata_o(rdata),
    .mode_o(cfg_mode_o), .refsel_o(cfg_refsel_o), .ctrl_o(cfg_ctrl_o));

  cfgring_out_stage u_out (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .xfer_i(in_x), .hit_i(hit), .rdata_i(rdata), .xfer_o(out_x));

  assign ring_vld_o  = out_x.vld;
  assign ring_wr_o   = out_x.wr;
  assign ring_ack_o  = out_x.ack;
  assign ring_addr_o = out_x.addr;
  assign ring_data_o = out_x.data;
endmodule

// File: rtl/cfgring_node_chk.sv
module cfgring_node_chk #(
  parameter logic [31:0] BASE = 32'h0000_0400,
  parameter int MODE_W   = 12,
  parameter int REFSEL_W = 2,
  parameter int CTRL_W   = 8,
  parameter int STAT_W   = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                ring_vld_i,
  input logic                ring_wr_i,
  input logic                ring_ack_i,
  input logic [31:0]         ring_addr_i,
  input logic [31:0]         ring_data_i,
  input logic                ring_vld_o,
  input logic                ring_wr_o,
  input logic                ring_ack_o,
  input logic [31:0]         ring_addr_o,
  input logic [31:0]         ring_data_o,
  input logic [STAT_W-1:0]   status_i,
  input logic [MODE_W-1:0]   cfg_mode_o,
  input logic [REFSEL_W-1:0] cfg_refsel_o,
  input logic [CTRL_W-1:0]   cfg_ctrl_o
);
  logic win, fresh, claim;
  assign win   = (ring_addr_i[31:4] == BASE[31:4]) && (ring_addr_i[1:0] == 2'b00);
  assign fresh = ring_vld_i && !ring_ack_i;
  assign claim = fresh && win;

  a_r3_idle_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ring_vld_i |=> !ring_vld_o && !ring_ack_o);

  a_r2_miss_forward: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fresh && !win |=> ring_vld_o && !ring_ack_o && ring_wr_o == $past(ring_wr_i)
      && ring_addr_o == $past(ring_addr_i) && ring_data_o == $past(ring_data_i));

  a_r4_write_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim && ring_wr_i |=> ring_vld_o && ring_ack_o && ring_wr_o
      && ring_addr_o == $past(ring_addr_i) && ring_data_o == $past(ring_data_i));

  a_r5_read_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim && !ring_wr_i |=> ring_vld_o && ring_ack_o && !ring_wr_o
      && ring_addr_o == $past(ring_addr_i));

  a_r6_status_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim && !ring_wr_i && ring_addr_i[3:2] == 2'd3
      |=> ring_data_o == {{(32-STAT_W){1'b0}}, $past(status_i)});

  a_r6_status_write_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim && ring_wr_i && ring_addr_i[3:2] == 2'd3
      |=> $stable(cfg_mode_o) && $stable(cfg_refsel_o) && $stable(cfg_ctrl_o));

  a_r8_acked_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ring_vld_i && ring_ack_i |=> ring_vld_o && ring_ack_o
      && ring_wr_o == $past(ring_wr_i) && ring_addr_o == $past(ring_addr_i)
      && ring_data_o == $past(ring_data_i)
      && $stable(cfg_mode_o) && $stable(cfg_refsel_o) && $stable(cfg_ctrl_o));
endmodule

bind cfgring_node cfgring_node_chk #(
  .BASE(BASE), .MODE_W(MODE_W), .REFSEL_W(REFSEL_W), .CTRL_W(CTRL_W), .STAT_W(STAT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .ring_vld_i(ring_vld_i), .ring_wr_i(ring_wr_i), .ring_ack_i(ring_ack_i),
  .ring_addr_i(ring_addr_i), .ring_data_i(ring_data_i),
  .ring_vld_o(ring_vld_o), .ring_wr_o(ring_wr_o), .ring_ack_o(ring_ack_o),
  .ring_addr_o(ring_addr_o), .ring_data_o(ring_data_o),
  .status_i(status_i), .cfg_mode_o(cfg_mode_o),
  .cfg_refsel_o(cfg_refsel_o), .cfg_ctrl_o(cfg_ctrl_o));

// File: tb/cfgring_node_tb_top.sv
module cfgring_node_tb_top;
  localparam logic [31:0] BASE = 32'h0000_0400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld_i = 0, wr_i = 0, ack_i = 0;
  logic [31:0] addr_i = '0, data_i = '0;
  logic vld_o, wr_o, ack_o;
  logic [31:0] addr_o, data_o;
  logic [7:0]  status = 8'h00;
  logic [11:0] mode;
  logic [1:0]  refsel;
  logic [7:0]  ctrl;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cfgring_node #(.BASE(BASE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ring_vld_i(vld_i), .ring_wr_i(wr_i), .ring_ack_i(ack_i),
    .ring_addr_i(addr_i), .ring_data_i(data_i),
    .ring_vld_o(vld_o), .ring_wr_o(wr_o), .ring_ack_o(ack_o),
    .ring_addr_o(addr_o), .ring_data_o(data_o),
    .status_i(status), .cfg_mode_o(mode), .cfg_refsel_o(refsel), .cfg_ctrl_o(ctrl));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge with outputs of this slot
  task automatic xfer(input logic wr, input logic [31:0] a, input logic [31:0] d,
                      input logic ak);
    vld_i = 1; wr_i = wr; addr_i = a; data_i = d; ack_i = ak;
    @(negedge clk);
    vld_i = 0; wr_i = 0; ack_i = 0; addr_i = '0; data_i = '0;
  endtask

  task automatic t_reset;
    chk("R1 vld", {31'd0, vld_o}, 0);
    chk("R1 ack", {31'd0, ack_o}, 0);
    chk("R1 mode", {20'd0, mode}, 32'h033);
    chk("R1 refsel", {30'd0, refsel}, 1);
    chk("R1 ctrl", {24'd0, ctrl}, 0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    chk("R3 vld", {31'd0, vld_o}, 0);
    chk("R3 ack", {31'd0, ack_o}, 0);
  endtask

  task automatic t_miss;
    xfer(1, 32'h0000_0800, 32'hDEAD_BEEF, 0);
    chk("R2 vld", {31'd0, vld_o}, 1);
    chk("R2 ack", {31'd0, ack_o}, 0);
    chk("R2 wr", {31'd0, wr_o}, 1);
    chk("R2 addr", addr_o, 32'h0000_0800);
    chk("R2 data", data_o, 32'hDEAD_BEEF);
    chk("R2 mode kept", {20'd0, mode}, 32'h033);
    xfer(0, BASE + 32'h10, 32'h1234_5678, 0);
    chk("R7 above window ack", {31'd0, ack_o}, 0);
    chk("R7 above window data", data_o, 32'h1234_5678);
    xfer(1, BASE + 32'h1, 32'h0000_0FFF, 0);
    chk("R7 misaligned ack", {31'd0, ack_o}, 0);
    chk("R7 misaligned mode", {20'd0, mode}, 32'h033);
  endtask

  task automatic t_write_read;
    xfer(1, BASE, 32'hABCD_E5A7, 0);
    chk("R4 ack", {31'd0, ack_o}, 1);
    chk("R4 data fwd", data_o, 32'hABCD_E5A7);
    chk("R4 addr fwd", addr_o, BASE);
    chk("R9 mode masked", {20'd0, mode}, 32'h5A7);
    xfer(1, BASE + 32'h4, 32'hFFFF_FFFE, 0);
    chk("R9 refsel masked", {30'd0, refsel}, 2);
    xfer(1, BASE + 32'h8, 32'h0000_1C3, 0);
    chk("R7 ctrl offset", {24'd0, ctrl}, 32'hC3);
    chk("R7 mode untouched", {20'd0, mode}, 32'h5A7);
    xfer(0, BASE, 32'hFFFF_FFFF, 0);
    chk("R5 ack", {31'd0, ack_o}, 1);
    chk("R5 wr", {31'd0, wr_o}, 0);
    chk("R5 mode read", data_o, 32'h0000_05A7);
    xfer(0, BASE + 32'h4, 32'h0, 0);
    chk("R5 refsel read", data_o, 32'h2);
    xfer(0, BASE + 32'h8, 32'h0, 0);
    chk("R5 ctrl read", data_o, 32'hC3);
  endtask

  task automatic t_status;
    status = 8'h9E;
    xfer(0, BASE + 32'hC, 32'h0, 0);
    chk("R6 status read", data_o, 32'h9E);
    chk("R6 status ack", {31'd0, ack_o}, 1);
    xfer(1, BASE + 32'hC, 32'hFFFF_FFFF, 0);
    chk("R6 write ack", {31'd0, ack_o}, 1);
    chk("R6 mode kept", {20'd0, mode}, 32'h5A7);
    chk("R6 refsel kept", {30'd0, refsel}, 2);
    chk("R6 ctrl kept", {24'd0, ctrl}, 32'hC3);
    status = 8'h41;
    xfer(0, BASE + 32'hC, 32'h0, 0);
    chk("R6 status after write", data_o, 32'h41);
  endtask

  task automatic t_acked;
    xfer(1, BASE, 32'h0000_0111, 1);
    chk("R8 ack", {31'd0, ack_o}, 1);
    chk("R8 data", data_o, 32'h0000_0111);
    chk("R8 wr", {31'd0, wr_o}, 1);
    chk("R8 mode kept", {20'd0, mode}, 32'h5A7);
    xfer(0, BASE + 32'h8, 32'h7777_0000, 1);
    chk("R8 read not served", data_o, 32'h7777_0000);
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_idle;
    t_miss;
    t_write_read;
    t_status;
    t_acked;
    t_idle;
    done = 1;
    report;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      report;
    end
  end
endmodule